// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the horizontal and vertical position counters of a raster display, together with blanking, horizontal sync and vertical sync strobes. Every timing value is a plain input that the logic uses directly, with no retiming, so a new value alters the decoded strobes in the same cycle. Only the run request is brought into the pixel clock domain through a synchroniser.

In progressive operation the vertical total gives the last line of a frame. With interlace enabled the same value gives the last line of the even field, and the odd field is one line longer. A field flag toggles at every field wrap. The vertical sync window starts at a (line, pixel) point and ends at another, and each field has its own pixel positions. Sync can therefore begin half-way along a line in one field and at the line start in the other.

While stopped, both counters sit on their terminal values. When the synchronised run request rises, the block emits a one-cycle reset for the downstream pipeline. On the next cycle it wraps to line 0, pixel 0 of an even field. Because the sync and blank lines lie at the top of the field, a complete vertical blanking interval with its vsync pulse always precedes the first active pixel after any restart.

Top module: `ilace_timing_gen`

## Requirements
- R1: While the synchronised run bit is low, from the next clock on: h_pos equals h_total, v_pos equals v_total plus 1 if ilace_en is 1 (else plus 0), field_odd equals ilace_en, blank is 1, and hsync and vsync are 0.
- R2: run_req passes through a two-stage synchroniser. pipe_rst is 1 for exactly one cycle, beginning after the second rising clock edge that samples run_req high. During that cycle blank is 1 and both syncs are 0.
- R3: In the cycle after pipe_rst, h_pos is 0, v_pos is 0 and field_odd is 0 (even field), in both modes.
- R4: While running, h_pos counts up by one per clock from 0 to h_total and then returns to 0. v_pos advances by one on each such return.
- R5: With ilace_en at 0, v_pos runs from 0 to v_total (v_total+1 lines per frame) and field_odd stays 0.
- R6: With ilace_en at 1, an even field (field_odd 0) has lines 0 to v_total and an odd field (field_odd 1) has lines 0 to v_total+1. field_odd inverts at every field wrap.
- R7: While running (outside the pipe_rst cycle), hsync is 1 exactly when hs_on <= h_pos < hs_off.
- R8: While running (outside the pipe_rst cycle), blank is 0 exactly when h_pos >= h_act_start and v_pos >= v_act_start.
- R9: While running, vsync is 1 from position (vs_line_first, on pixel) up to but excluding (vs_line_last, off pixel), in line-then-pixel order. The on/off pixels are vs_even_on/vs_even_off when field_odd is 0 and vs_odd_on/vs_odd_off when field_odd is 1.
- R10: A change to any timing input other than run_req alters the decoded strobes in the same cycle, with no synchronisation delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Run/stop request, asynchronous to clk |
| ilace_en | input | 1 | Interlace enable |
| h_total | input | HW | Last pixel index of a line |
| h_act_start | input | HW | First active pixel |
| hs_on | input | HW | Horizontal sync first pixel |
| hs_off | input | HW | Pixel where horizontal sync ends |
| v_total | input | VW | Last line of a frame or even field |
| v_act_start | input | VW | First active line |
| vs_line_first | input | VW | Line on which vertical sync begins |
| vs_line_last | input | VW | Line on which vertical sync ends |
| vs_even_on | input | HW | Vsync start pixel, even field |
| vs_even_off | input | HW | Vsync end pixel, even field |
| vs_odd_on | input | HW | Vsync start pixel, odd field |
| vs_odd_off | input | HW | Vsync end pixel, odd field |
| h_pos | output | HW | Horizontal position |
| v_pos | output | VW | Vertical position within field |
| field_odd | output | 1 | 1 during an odd field |
| blank | output | 1 | Blanking strobe |
| hsync | output | 1 | Horizontal sync strobe |
| vsync | output | 1 | Vertical sync strobe |
| pipe_rst | output | 1 | One-cycle downstream pipeline reset |

## Verification
The hardest case to reach is the odd field. It has its extra line, and its vsync pixel pair lies across a line boundary, so that the pulse starts mid-line and ends before the start pixel of the next line. A run only arrives there after a full even field following a restart. The stimulus uses very small totals so that several complete even/odd field pairs fit in a short run. It also stops and restarts the block in each mode to cover the synchroniser delay, the restart pulse and the first-field origin.

// File: rtl/ilace_timing_pkg.sv
package ilace_timing_pkg;

  localparam int COORD_W = 16;
  typedef logic [COORD_W-1:0] coord_t;

  // Line-then-pixel ordering: true when (v,h) is at or beyond (rv,rh).
  function automatic logic at_or_after(input coord_t v, input coord_t h,
                                       input coord_t rv, input coord_t rh);
    return (v > rv) || ((v == rv) && (h >= rh));
  endfunction

  // Half-open span test lo <= x < hi.
  function automatic logic in_span(input coord_t x, input coord_t lo, input coord_t hi);
    return (x >= lo) && (x < hi);
  endfunction

  // Last line of the current field: odd interlaced fields get one extra line.
  function automatic coord_t field_last_line(input coord_t vt, input logic odd,
                                             input logic il);
    return vt + coord_t'(odd & il);
  endfunction

endpackage

// File: rtl/tg_run_sync.sv
module tg_run_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  output logic run_q,
  output logic pipe_rst
);
  logic [STAGES-1:0] chain;
  logic              run_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= run_req;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], run_req};
      end
    end
  endgenerate

  assign run_q = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) run_prev <= 1'b0;
    else        run_prev <= run_q;
  end

  assign pipe_rst = run_q & ~run_prev;
endmodule

// File: rtl/tg_hcount.sv
module tg_hcount #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_q,
  input  logic [HW-1:0] h_total,
  output logic [HW-1:0] h_pos,
  output logic          line_wrap
);
  assign line_wrap = (h_pos >= h_total);

  always_ff @(posedge clk) begin
    if (!rst_n)         h_pos <= '0;
    else if (!run_q)    h_pos <= h_total;
    else if (line_wrap) h_pos <= '0;
    else                h_pos <= h_pos + HW'(1);
  end
endmodule

// File: rtl/tg_vcount.sv
module tg_vcount
  import ilace_timing_pkg::*;
#(
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_q,
  input  logic          line_wrap,
  input  logic          ilace_en,
  input  logic [VW-1:0] v_total,
  output logic [VW-1:0] v_pos,
  output logic          field_odd,
  output logic          field_wrap
);
  logic [VW-1:0] v_end;

  assign v_end      = VW'(field_last_line(coord_t'(v_total), field_odd, ilace_en));
  assign field_wrap = line_wrap && (v_pos >= v_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_pos     <= '0;
      field_odd <= 1'b0;
    end else if (!run_q) begin
      v_pos     <= VW'(field_last_line(coord_t'(v_total), 1'b1, ilace_en));
      field_odd <= ilace_en;
    end else if (field_wrap) begin
      v_pos     <= '0;
      field_odd <= ilace_en ? ~field_odd : 1'b0;
    end else if (line_wrap) begin
      v_pos     <= v_pos + VW'(1);
    end
  end
endmodule

// File: rtl/tg_strobes.sv
module tg_strobes
  import ilace_timing_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          live,
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_pos,
  input  logic          field_odd,
  input  logic [HW-1:0] h_act_start,
  input  logic [VW-1:0] v_act_start,
  input  logic [HW-1:0] hs_on,
  input  logic [HW-1:0] hs_off,
  input  logic [VW-1:0] vs_line_first,
  input  logic [VW-1:0] vs_line_last,
  input  logic [HW-1:0] vs_even_on,
  input  logic [HW-1:0] vs_even_off,
  input  logic [HW-1:0] vs_odd_on,
  input  logic [HW-1:0] vs_odd_off,
  output logic          blank,
  output logic          hsync,
  output logic          vsync
);
  coord_t hc, vc, on_pix, off_pix;
  logic   active_area, past_start, past_stop;

  always_comb begin
    hc      = coord_t'(h_pos);
    vc      = coord_t'(v_pos);
    on_pix  = coord_t'(field_odd ? vs_odd_on  : vs_even_on);
    off_pix = coord_t'(field_odd ? vs_odd_off : vs_even_off);

    active_area = (hc >= coord_t'(h_act_start)) && (vc >= coord_t'(v_act_start));
    past_start  = at_or_after(vc, hc, coord_t'(vs_line_first), on_pix);
    past_stop   = at_or_after(vc, hc, coord_t'(vs_line_last), off_pix);

    blank = !(live && active_area);
    hsync = live && in_span(hc, coord_t'(hs_on), coord_t'(hs_off));
    vsync = live && past_start && !past_stop;
  end
endmodule

// File: rtl/ilace_timing_gen.sv
module ilace_timing_gen
  import ilace_timing_pkg::*;
#(
  parameter int HW        = 12,
  parameter int VW        = 11,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_req,
  input  logic          ilace_en,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_act_start,
  input  logic [HW-1:0] hs_on,
  input  logic [HW-1:0] hs_off,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_act_start,
  input  logic [VW-1:0] vs_line_first,
  input  logic [VW-1:0] vs_line_last,
  input  logic [HW-1:0] vs_even_on,
  input  logic [HW-1:0] vs_even_off,
  input  logic [HW-1:0] vs_odd_on,
  input  logic [HW-1:0] vs_odd_off,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          field_odd,
  output logic          blank,
  output logic          hsync,
  output logic          vsync,
  output logic          pipe_rst
);
  // Named internal events, observed by the bound checker.
  logic run_q;
  logic live;
  logic line_wrap;
  logic field_wrap;

  tg_run_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .run_req(run_req),
    .run_q(run_q), .pipe_rst(pipe_rst)
  );

  assign live = run_q & ~pipe_rst;

  tg_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .h_total(h_total),
    .h_pos(h_pos), .line_wrap(line_wrap)
  );

  tg_vcount #(.VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .line_wrap(line_wrap),
    .ilace_en(ilace_en), .v_total(v_total),
    .v_pos(v_pos), .field_odd(field_odd), .field_wrap(field_wrap)
  );

  tg_strobes #(.HW(HW), .VW(VW)) u_dec (
    .live(live), .h_pos(h_pos), .v_pos(v_pos), .field_odd(field_odd),
    .h_act_start(h_act_start), .v_act_start(v_act_start),
    .hs_on(hs_on), .hs_off(hs_off),
    .vs_line_first(vs_line_first), .vs_line_last(vs_line_last),
    .vs_even_on(vs_even_on), .vs_even_off(vs_even_off),
    .vs_odd_on(vs_odd_on), .vs_odd_off(vs_odd_off),
    .blank(blank), .hsync(hsync), .vsync(vsync)
  );
endmodule

// File: rtl/ilace_timing_chk.sv
module ilace_timing_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_q,
  input logic          pipe_rst,
  input logic          line_wrap,
  input logic          field_wrap,
  input logic          ilace_en,
  input logic [HW-1:0] h_pos,
  input logic [VW-1:0] v_pos,
  input logic          field_odd,
  input logic          blank,
  input logic          hsync,
  input logic          vsync
);
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (blank && !hsync && !vsync));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_rst |=> !pipe_rst);

  assert_restart_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_rst |=> (h_pos == '0 && v_pos == '0 && !field_odd));

  assert_pixel_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !line_wrap) |=> (h_pos == $past(h_pos) + HW'(1)));

  assert_prog_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && field_wrap && !ilace_en) |=> !field_odd);

  assert_field_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && field_wrap && ilace_en) |=> (field_odd != $past(field_odd)));
endmodule

bind ilace_timing_gen ilace_timing_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .pipe_rst(pipe_rst),
  .line_wrap(line_wrap), .field_wrap(field_wrap), .ilace_en(ilace_en),
  .h_pos(h_pos), .v_pos(v_pos), .field_odd(field_odd),
  .blank(blank), .hsync(hsync), .vsync(vsync)
);

// File: tb/ilace_timing_gen_test.sv
module ilace_timing_gen_test;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_req = 1'b0, ilace_en = 1'b0;
  logic [HW-1:0] h_total, h_act_start, hs_on, hs_off;
  logic [VW-1:0] v_total, v_act_start, vs_line_first, vs_line_last;
  logic [HW-1:0] vs_even_on, vs_even_off, vs_odd_on, vs_odd_off;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic field_odd, blank, hsync, vsync, pipe_rst;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  ilace_timing_gen #(.HW(HW), .VW(VW)) uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: run-request history and raster position.
  bit s1, s2, sp;
  int mh, mv, mf;

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; sp = 0; mh = 0; mv = 0; mf = 0;
    end else begin
      if (s2) begin
        if (mh >= int'(h_total)) begin
          mh = 0;
          if (mv >= int'(v_total) + ((ilace_en && mf == 1) ? 1 : 0)) begin
            mv = 0;
            mf = ilace_en ? 1 - mf : 0;
          end else mv = mv + 1;
        end else mh = mh + 1;
      end else begin
        mh = int'(h_total);
        mv = int'(v_total) + (ilace_en ? 1 : 0);
        mf = ilace_en ? 1 : 0;
      end
      sp = s2; s2 = s1; s1 = run_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit pr, lv, exp_blank, exp_hs, exp_vs, a, b;
      int on, off;
      pr = s2 && !sp;
      lv = s2 && !pr;
      on  = mf ? int'(vs_odd_on)  : int'(vs_even_on);
      off = mf ? int'(vs_odd_off) : int'(vs_even_off);
      a = (mv > int'(vs_line_first)) || (mv == int'(vs_line_first) && mh >= on);
      b = (mv > int'(vs_line_last))  || (mv == int'(vs_line_last)  && mh >= off);
      exp_blank = !(lv && mh >= int'(h_act_start) && mv >= int'(v_act_start));
      exp_hs = lv && mh >= int'(hs_on) && mh < int'(hs_off);
      exp_vs = lv && a && !b;
      check("R2", "pipe_rst", int'(pipe_rst), int'(pr));
      check("R4", "h_pos", int'(h_pos), mh);
      check(ilace_en ? "R6" : "R5", "v_pos", int'(v_pos), mv);
      check(ilace_en ? "R6" : "R5", "field_odd", int'(field_odd), mf);
      check("R8", "blank", int'(blank), int'(exp_blank));
      check("R7", "hsync", int'(hsync), int'(exp_hs));
      check("R9", "vsync", int'(vsync), int'(exp_vs));
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  // Restart and verify the one-cycle reset pulse and the field origin.
  task automatic start_and_check_origin();
    int waited = 0;
    run_req = 1'b1;
    tick(1);
    check("R2", "pipe_rst before sync", int'(pipe_rst), 0);
    tick(1);
    check("R2", "pipe_rst after two edges", int'(pipe_rst), 1);
    check("R2", "blank during pipe_rst", int'(blank), 1);
    tick(1);
    waited = int'(h_pos) + int'(v_pos) + int'(field_odd);
    check("R3", "origin h+v+field", waited, 0);
    check("R3", "first line blanked", int'(blank), 1);
  endtask

  initial begin
    h_total = 19; h_act_start = 6; hs_on = 1; hs_off = 3;
    v_total = 9; v_act_start = 4; vs_line_first = 1; vs_line_last = 2;
    vs_even_on = 2; vs_even_off = 15; vs_odd_on = 12; vs_odd_off = 5;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // Stopped state, progressive.
    check("R1", "h_pos stopped", int'(h_pos), 19);
    check("R1", "v_pos stopped", int'(v_pos), 9);
    check("R1", "blank stopped", int'(blank), 1);
    // Stopped state follows interlace setting.
    ilace_en = 1'b1;
    tick(1);
    check("R1", "v_pos stopped interlaced", int'(v_pos), 10);
    check("R1", "field stopped interlaced", int'(field_odd), 1);
    ilace_en = 1'b0;
    tick(1);

    // Progressive: two frames.
    start_and_check_origin();
    tick(2 * 20 * 10 + 7);
    run_req = 1'b0;
    tick(4);
    check("R1", "h_pos after stop", int'(h_pos), 19);
    check("R1", "vsync after stop", int'(vsync), 0);

    // Interlaced: several field pairs.
    ilace_en = 1'b1;
    tick(2);
    start_and_check_origin();
    tick(20 * 10 + 20 * 11 + 13);
    // Timing input change takes effect in the same cycle.
    begin
      int guard = 0;
      while (h_pos != 5 && guard < 100) begin tick(1); guard++; end
      check("R10", "hsync before change", int'(hsync), 0);
      hs_off = 10;
      #1;
      check("R10", "hsync right after change", int'(hsync), 1);
    end
    tick(2 * (20 * 10 + 20 * 11));
    run_req = 1'b0;
    tick(4);
    check("R1", "v_pos after interlaced stop", int'(v_pos), 10);
    finish_run();
  end
endmodule